// File: doc/BRIEF.md
# Bridge Error Capture Unit

This unit sits beside the two protocol engines of a bridge that joins a PCI-style bus to an AHB-style system bus. It watches the completion responses coming back on each side and turns every failure into sticky status, a captured faulting address and, when enabled, an interrupt. When a request travels upstream (from the PCI side toward the AHB side) and its address or data parity is bad, the unit withholds the request from the AHB master engine. When an upstream read is answered with an AHB error, the unit asks the PCI target engine, in that same cycle, to end the transaction with a target abort.

Software reaches the unit through a small word-wide register port. The port has a select, a write strobe and write data, and its read data is combinational. The status words are cleared by writing ones. The enable word is written directly. The two address words are read-only.

Top module: `xbe_top`

## Requirements
- R1: After reset every status bit, every enable bit and both captured addresses read zero, and `irq` and `abortReq` are low.
- R2: An AHB completion with `ahbRespValid` and `ahbRespErr` high sets bridge status bit 0 (select 0), whether the access is a read or a write. The bit stays set until a write to select 0 with data bit 0 at one.
- R3: The AHB error address (select 3) captures `ahbRespAddr` on an AHB error only while bridge status bit 0 is clear. It then holds that value while the bit remains set.
- R4: `abortReq` is high in exactly those cycles where an AHB error completion has `ahbRespIsRead` high. The same event sets PCI status bit 11 (select 1).
- R5: A downstream PCI completion with `pciRespValid` and `pciRespErr` high sets a PCI status bit chosen by `pciErrKind`: 0 (parity) sets bit 15, 1 (system error) sets bit 14, 2 (master abort) sets bit 13 and 3 (target abort) sets bit 12. It also sets summary bit 4. The PCI error address (select 4) captures `pciRespAddr` only while bit 4 is clear.
- R6: `fwdValid` equals `upReqValid` with neither `upAddrParErr` nor `upDataParErr` high. An upstream request with a parity failure sets PCI status bit 15.
- R7: `irq` is a registered level. In each cycle it equals the OR, taken one clock earlier, of bridge bit 0 ANDed with enable bit 0 and of PCI status bits 15..11 ANDed with enable bits 15..11.
- R8: The enable word (select 2) stores write data bits 15..11 and bit 0. All other bits read zero.
- R9: When a set and a write-one clear hit the same status bit in one cycle, the set wins. Errors from both directions in one cycle each capture their own address.
- R10: PCI status writes clear only bits 15..11 and 4. Selects 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upReqValid | input | 1 | Upstream request offered by the PCI target engine |
| upAddrParErr | input | 1 | Address parity failure on that request |
| upDataParErr | input | 1 | Data parity failure on that request |
| fwdValid | output | 1 | Request passed on to the AHB master engine |
| ahbRespValid | input | 1 | AHB completion for an upstream access |
| ahbRespErr | input | 1 | That completion is an error response |
| ahbRespIsRead | input | 1 | That access was a read |
| ahbRespAddr | input | ADDR_W | AHB address of the access |
| abortReq | output | 1 | Target abort request pulse to the PCI target engine |
| pciRespValid | input | 1 | PCI completion for a downstream access |
| pciRespErr | input | 1 | That completion failed |
| pciErrKind | input | 2 | Failure kind: 0 parity, 1 system error, 2 master abort, 3 target abort |
| pciRespAddr | input | ADDR_W | PCI address of the access |
| regSel | input | 3 | Register select |
| regWr | input | 1 | Register write strobe |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data for `regSel` |
| irq | output | 1 | Interrupt level |

## Verification
The error inputs are driven with random mixes. In these mixes AHB read errors, AHB write errors, the four PCI failure kinds and parity failures overlap freely with write-one clears, so the bench can tell whether each source sets only its own bit and whether a held address is overwritten by a later fault. Directed cases then isolate the patterns that random runs rarely line up:
- a read error arriving while a write error is already held, which checks that the address is kept and the abort is still raised;
- both directions failing in one cycle, which shows whether the two captures are independent;
- a clear that coincides with a new error, which shows whether set wins;
- enable writes with every bit set, which separates the interrupt-capable fields from reserved ones.

// File: rtl/xbe_pkg.sv
package xbe_pkg;

  localparam int SEL_W = 3;
  localparam int STAT_W = 16;

  localparam logic [SEL_W-1:0] SEL_BRIDGE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_PCI    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_EN     = 3'd2;
  localparam logic [SEL_W-1:0] SEL_AHBADR = 3'd3;
  localparam logic [SEL_W-1:0] SEL_PCIADR = 3'd4;

  // implemented bits of the PCI status word and of the enable word
  localparam logic [STAT_W-1:0] PCI_STAT_MASK = 16'hF810;
  localparam logic [STAT_W-1:0] EN_MASK       = 16'hF801;

  localparam int PCI_SUM_BIT   = 4;
  localparam int PCI_SIGTA_BIT = 11;
  localparam int PCI_DPE_BIT   = 15;
  localparam int NUM_KINDS     = 4;

  typedef enum logic [1:0] {
    KIND_PARITY = 2'd0,
    KIND_SYSERR = 2'd1,
    KIND_MABORT = 2'd2,
    KIND_TABORT = 2'd3
  } pciErrKind_t;

  typedef struct packed {
    logic              setAhb;
    logic              capAhbAddr;
    logic [STAT_W-1:0] pciSet;
    logic              capPciAddr;
    logic              clrBridge;
    logic [STAT_W-1:0] pciClr;
    logic              enWr;
    logic [STAT_W-1:0] wrData;
  } ctlStrb_t;

endpackage

// File: rtl/xbe_ctrl.sv
module xbe_ctrl
  import xbe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              upReqValid,
  input  logic              upAddrParErr,
  input  logic              upDataParErr,
  input  logic              ahbRespValid,
  input  logic              ahbRespErr,
  input  logic              ahbRespIsRead,
  input  logic              pciRespValid,
  input  logic              pciRespErr,
  input  pciErrKind_t       pciErrKind,
  input  logic              regWr,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              ahbStatBit,
  input  logic              pciSumBit,
  output ctlStrb_t          strb,
  output logic              fwdValid,
  output logic              abortReq
);

  logic ahbErrEv;
  logic parFail;
  logic pciErrEv;
  logic [NUM_KINDS-1:0] kindHit;
  logic unusedHiBits;

  assign ahbErrEv = ahbRespValid & ahbRespErr;
  assign parFail  = upReqValid & (upAddrParErr | upDataParErr);
  assign pciErrEv = pciRespValid & pciRespErr;

  // parity-failed requests never reach the AHB master engine
  assign fwdValid = upReqValid & ~upAddrParErr & ~upDataParErr;
  // same-cycle abort for a failed upstream read
  assign abortReq = ahbErrEv & ahbRespIsRead;

  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_kind
      assign kindHit[k] = pciErrEv & (pciErrKind == pciErrKind_t'(k));
    end
  endgenerate

  generate
    if (DATA_W > STAT_W) begin : g_hi
      assign unusedHiBits = ^regWdata[DATA_W-1:STAT_W];
    end else begin : g_nohi
      assign unusedHiBits = 1'b0;
    end
  endgenerate

  always_comb begin
    strb = '0;
    strb.setAhb     = ahbErrEv;
    strb.capAhbAddr = ahbErrEv & ~ahbStatBit;
    for (int i = 0; i < NUM_KINDS; i++) begin
      strb.pciSet[PCI_DPE_BIT-i] = kindHit[i];
    end
    strb.pciSet[PCI_DPE_BIT]   = strb.pciSet[PCI_DPE_BIT] | parFail;
    strb.pciSet[PCI_SIGTA_BIT] = abortReq;
    strb.pciSet[PCI_SUM_BIT]   = pciErrEv;
    strb.capPciAddr = pciErrEv & ~pciSumBit;
    strb.clrBridge  = regWr & (regSel == SEL_BRIDGE) & regWdata[0];
    strb.pciClr     = (regWr && regSel == SEL_PCI) ? (regWdata[STAT_W-1:0] & PCI_STAT_MASK) : '0;
    strb.enWr       = regWr & (regSel == SEL_EN);
    strb.wrData     = regWdata[STAT_W-1:0];
  end

endmodule

// File: rtl/xbe_data.sv
module xbe_data
  import xbe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] ahbRespAddr,
  input  logic [ADDR_W-1:0] pciRespAddr,
  input  logic [SEL_W-1:0]  regSel,
  output logic [DATA_W-1:0] regRdata,
  output logic              statBridge,
  output logic [STAT_W-1:0] statPci,
  output logic [STAT_W-1:0] enReg,
  output logic [ADDR_W-1:0] ahbErrAddr,
  output logic [ADDR_W-1:0] pciErrAddr,
  output logic              irq
);

  localparam int NUM_SRC = 6;

  logic [NUM_SRC-1:0] srcVec;
  logic [NUM_SRC-1:0] srcEn;
  logic irqNext;

  // source 0 is the bridge bit, sources 1..5 are PCI status bits 11..15
  assign srcVec[0] = statBridge;
  assign srcEn[0]  = enReg[0];
  genvar s;
  generate
    for (s = 1; s < NUM_SRC; s++) begin : g_src
      assign srcVec[s] = statPci[PCI_SIGTA_BIT+s-1];
      assign srcEn[s]  = enReg[PCI_SIGTA_BIT+s-1];
    end
  endgenerate

  assign irqNext = |(srcVec & srcEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statBridge <= 1'b0;
      statPci    <= '0;
      enReg      <= '0;
      ahbErrAddr <= '0;
      pciErrAddr <= '0;
      irq        <= 1'b0;
    end else begin
      statBridge <= (statBridge & ~strb.clrBridge) | strb.setAhb;
      statPci    <= (statPci & ~strb.pciClr) | strb.pciSet;
      if (strb.enWr) enReg <= strb.wrData & EN_MASK;
      if (strb.capAhbAddr) ahbErrAddr <= ahbRespAddr;
      if (strb.capPciAddr) pciErrAddr <= pciRespAddr;
      irq <= irqNext;
    end
  end

  always_comb begin
    case (regSel)
      SEL_BRIDGE: regRdata = DATA_W'(statBridge);
      SEL_PCI:    regRdata = DATA_W'(statPci);
      SEL_EN:     regRdata = DATA_W'(enReg);
      SEL_AHBADR: regRdata = DATA_W'(ahbErrAddr);
      SEL_PCIADR: regRdata = DATA_W'(pciErrAddr);
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/xbe_top.sv
module xbe_top
  import xbe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upReqValid,
  input  logic              upAddrParErr,
  input  logic              upDataParErr,
  output logic              fwdValid,
  input  logic              ahbRespValid,
  input  logic              ahbRespErr,
  input  logic              ahbRespIsRead,
  input  logic [ADDR_W-1:0] ahbRespAddr,
  output logic              abortReq,
  input  logic              pciRespValid,
  input  logic              pciRespErr,
  input  logic [1:0]        pciErrKind,
  input  logic [ADDR_W-1:0] pciRespAddr,
  input  logic [2:0]        regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irq
);

  ctlStrb_t          strb;
  logic              statBridge;
  logic [STAT_W-1:0] statPci;
  logic [STAT_W-1:0] enReg;
  logic [ADDR_W-1:0] ahbErrAddr;
  logic [ADDR_W-1:0] pciErrAddr;

  xbe_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .upReqValid   (upReqValid),
    .upAddrParErr (upAddrParErr),
    .upDataParErr (upDataParErr),
    .ahbRespValid (ahbRespValid),
    .ahbRespErr   (ahbRespErr),
    .ahbRespIsRead(ahbRespIsRead),
    .pciRespValid (pciRespValid),
    .pciRespErr   (pciRespErr),
    .pciErrKind   (pciErrKind_t'(pciErrKind)),
    .regWr        (regWr),
    .regSel       (regSel),
    .regWdata     (regWdata),
    .ahbStatBit   (statBridge),
    .pciSumBit    (statPci[PCI_SUM_BIT]),
    .strb         (strb),
    .fwdValid     (fwdValid),
    .abortReq     (abortReq)
  );

  xbe_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ahbRespAddr(ahbRespAddr),
    .pciRespAddr(pciRespAddr),
    .regSel     (regSel),
    .regRdata   (regRdata),
    .statBridge (statBridge),
    .statPci    (statPci),
    .enReg      (enReg),
    .ahbErrAddr (ahbErrAddr),
    .pciErrAddr (pciErrAddr),
    .irq        (irq)
  );

endmodule

// File: rtl/xbe_chk.sv
module xbe_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              upReqValid,
  input logic              upAddrParErr,
  input logic              upDataParErr,
  input logic              fwdValid,
  input logic              ahbRespValid,
  input logic              ahbRespErr,
  input logic              ahbRespIsRead,
  input logic              abortReq,
  input logic              pciRespValid,
  input logic              pciRespErr,
  input logic              clrBridgeWr,
  input logic              statBridge,
  input logic [15:0]       statPci,
  input logic [15:0]       enReg,
  input logic [ADDR_W-1:0] ahbErrAddr,
  input logic              irq
);

  AST_PARITY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (upAddrParErr || upDataParErr) |-> !fwdValid); // R6
  AST_FWD_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (upReqValid && !upAddrParErr && !upDataParErr) |-> fwdValid); // R6
  AST_ABORT_ONLY_RD: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (ahbRespValid && ahbRespErr && ahbRespIsRead)); // R4
  AST_ABORT_SETS_STA: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> statPci[11]); // R4
  AST_AHB_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (statBridge && !clrBridgeWr) |=> statBridge); // R2
  AST_AHB_ERR_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (ahbRespValid && ahbRespErr) |=> statBridge); // R9
  AST_AHB_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    statBridge |=> $stable(ahbErrAddr)); // R3
  AST_PCI_SUMMARY: assert property (@(posedge clk) disable iff (!rstN)
    (pciRespValid && pciRespErr) |=> statPci[4]); // R5
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (irq == $past(|({statPci[15:11], statBridge} & {enReg[15:11], enReg[0]})))); // R7

endmodule

bind xbe_top xbe_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .upReqValid   (upReqValid),
  .upAddrParErr (upAddrParErr),
  .upDataParErr (upDataParErr),
  .fwdValid     (fwdValid),
  .ahbRespValid (ahbRespValid),
  .ahbRespErr   (ahbRespErr),
  .ahbRespIsRead(ahbRespIsRead),
  .abortReq     (abortReq),
  .pciRespValid (pciRespValid),
  .pciRespErr   (pciRespErr),
  .clrBridgeWr  (regWr && regSel == 3'd0 && regWdata[0]),
  .statBridge   (statBridge),
  .statPci      (statPci),
  .enReg        (enReg),
  .ahbErrAddr   (ahbErrAddr),
  .irq          (irq)
);

// File: tb/sim_xbe_top.sv
module sim_xbe_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upReqValid = 0, upAddrParErr = 0, upDataParErr = 0;
  logic fwdValid;
  logic ahbRespValid = 0, ahbRespErr = 0, ahbRespIsRead = 0;
  logic [AW-1:0] ahbRespAddr = '0;
  logic abortReq;
  logic pciRespValid = 0, pciRespErr = 0;
  logic [1:0] pciErrKind = '0;
  logic [AW-1:0] pciRespAddr = '0;
  logic [2:0] regSel = '0;
  logic regWr = 0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic irq;

  int checks = 0;
  int fails = 0;

  // bench model of the register state
  logic        mBridge = 0;
  logic [15:0] mPci = '0;
  logic [15:0] mEn = '0;
  logic [31:0] mAhbAddr = '0;
  logic [31:0] mPciAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbe_top #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN),
    .upReqValid(upReqValid), .upAddrParErr(upAddrParErr), .upDataParErr(upDataParErr),
    .fwdValid(fwdValid),
    .ahbRespValid(ahbRespValid), .ahbRespErr(ahbRespErr), .ahbRespIsRead(ahbRespIsRead),
    .ahbRespAddr(ahbRespAddr), .abortReq(abortReq),
    .pciRespValid(pciRespValid), .pciRespErr(pciRespErr), .pciErrKind(pciErrKind),
    .pciRespAddr(pciRespAddr),
    .regSel(regSel), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata),
    .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [2:0] sel);
    case (sel)
      3'd0: return {31'd0, mBridge};
      3'd1: return {16'd0, mPci};
      3'd2: return {16'd0, mEn};
      3'd3: return mAhbAddr;
      3'd4: return mPciAddr;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string selTag(input logic [2:0] sel);
    case (sel)
      3'd0: return "R2 bridge status";
      3'd1: return "R5/R10 pci status";
      3'd2: return "R8 enable";
      3'd3: return "R3 ahb address";
      3'd4: return "R5 pci address";
      default: return "R10 unmapped";
    endcase
  endfunction

  function automatic logic expIrq();
    return (mBridge & mEn[0]) | (|(mPci[15:11] & mEn[15:11]));
  endfunction

  // one clock: starts just after a falling edge, ends at the next falling edge
  task automatic cyc(input bit uv, input bit ap, input bit dp,
                     input bit av, input bit ae, input bit ard, input logic [31:0] aa,
                     input bit pv, input bit pe, input logic [1:0] pk, input logic [31:0] pa,
                     input bit wr, input logic [2:0] sel, input logic [31:0] wd);
    logic ahbEv, pciEv, parEv, nb, irqExp;
    logic [15:0] np;
    upReqValid = uv; upAddrParErr = ap; upDataParErr = dp;
    ahbRespValid = av; ahbRespErr = ae; ahbRespIsRead = ard; ahbRespAddr = aa;
    pciRespValid = pv; pciRespErr = pe; pciErrKind = pk; pciRespAddr = pa;
    regWr = wr; regSel = sel; regWdata = wd;
    #1;
    chk("R6 fwdValid", {31'd0, fwdValid}, {31'd0, uv & ~ap & ~dp});
    chk("R4 abortReq", {31'd0, abortReq}, {31'd0, av & ae & ard});
    chk(selTag(sel), regRdata, expRead(sel));
    // model next state
    ahbEv = av & ae;
    pciEv = pv & pe;
    parEv = uv & (ap | dp);
    irqExp = expIrq();
    nb = mBridge; np = mPci;
    if (wr && sel == 3'd0 && wd[0]) nb = 1'b0;
    if (wr && sel == 3'd1) np = np & ~(wd[15:0] & 16'hF810);
    if (ahbEv) nb = 1'b1;
    if (ahbEv && ard) np[11] = 1'b1;
    if (parEv) np[15] = 1'b1;
    if (pciEv) begin
      np[15 - pk] = 1'b1;
      np[4] = 1'b1;
    end
    if (ahbEv && !mBridge) mAhbAddr = aa;
    if (pciEv && !mPci[4]) mPciAddr = pa;
    if (wr && sel == 3'd2) mEn = wd[15:0] & 16'hF801;
    mBridge = nb; mPci = np;
    @(posedge clk);
    #1;
    chk("R7 irq", {31'd0, irq}, {31'd0, irqExp});
    @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] sel);
    cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 0,sel,'0);
  endtask

  bit done = 0;

  initial begin
    int unsigned seedv;
    seedv = 32'h1bad5eed;
    void'($urandom(seedv));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state on every select and on the outputs
    for (int s = 0; s < 8; s++) begin
      chk("R1 reset read", regRdata, 32'd0);
      idle(3'(s));
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 abortReq after reset", {31'd0, abortReq}, 32'd0);

    // R8: enable every interrupt-capable bit
    cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 1,3'd2,32'hFFFF_FFFF);
    idle(3'd2);

    // R2/R3: AHB write error, then a read error while held
    cyc(0,0,0, 1,1,0,32'hA000_0010, 0,0,2'd0,'0, 0,3'd3,'0);
    idle(3'd3);
    cyc(0,0,0, 1,1,1,32'hA000_0020, 0,0,2'd0,'0, 0,3'd3,'0); // R4 abort, R3 hold
    idle(3'd3);
    idle(3'd1);

    // clear everything, then both directions fail together (R9)
    cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 1,3'd0,32'h1);
    cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 1,3'd1,32'hFFFF_FFFF);
    idle(3'd1);
    cyc(0,0,0, 1,1,0,32'hB000_0004, 1,1,2'd2,32'hC000_0008, 0,3'd0,'0);
    idle(3'd3);
    idle(3'd4);
    idle(3'd1);

    // R9: clear and set of bridge bit in the same cycle, set wins
    cyc(0,0,0, 1,1,0,32'hD000_0000, 0,0,2'd0,'0, 1,3'd0,32'h1);
    idle(3'd0);

    // R10: write to pci status with reserved bits only clears nothing
    cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 1,3'd1,32'h0000_07EF);
    idle(3'd1);

    // R6: parity filter, address and data variants
    cyc(1,1,0, 0,0,0,'0, 0,0,2'd0,'0, 0,3'd1,'0);
    cyc(1,0,1, 0,0,0,'0, 0,0,2'd0,'0, 0,3'd1,'0);
    cyc(1,0,0, 0,0,0,'0, 0,0,2'd0,'0, 0,3'd1,'0);

    // R5: each PCI failure kind in isolation
    for (int k = 0; k < 4; k++) begin
      cyc(0,0,0, 0,0,0,'0, 0,0,2'd0,'0, 1,3'd1,32'hFFFF);
      cyc(0,0,0, 0,0,0,'0, 1,1,2'(k),32'h5000_0000 + 32'(k), 0,3'd1,'0);
      idle(3'd1);
      idle(3'd4);
    end

    // constrained random mix
    for (int i = 0; i < RAND_CYCLES; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], r[1] & r[2], r[3] & r[4] & r[5],
          r[6], r[7] & r[8], r[9], $urandom,
          r[10], r[11] & r[12], r[14:13], $urandom,
          (r[17:15] == 3'd0), r[20:18], (r[21] ? 32'hFFFF_FFFF : $urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule